// File: doc/BRIEF.md
# Three-Dimensional Register Index Remapper

This block turns the element number of a vector register access into a permuted linear index. Software programs up to three shape descriptors. Each one gives the extents of a 3D volume, three per-dimension offset flags and a permutation code that sets the order in which the dimensions are walked. Writing a descriptor starts a fill engine. The engine steps a nested X/Y/Z counter one entry per cycle and stores the linear index `x + y*xsz + z*xsz*ysz` of each counter state into a 128-entry table owned by that shape.

A separate binding register ties up to three register numbers to shapes. During execution a lookup presents a register number, a privilege level and an element number. When remapping applies, the element is translated through the bound shape's table. Otherwise it passes through unchanged. A lookup is refused while a fill is in progress.

Top module: `shape_remapper`

## Requirements
- R1: After reset `busy` and `res_valid` are low, `lk_ready` is high, and all bindings are cleared, so every lookup passes through unremapped.
- R2: In a descriptor word the X, Y and Z extents sit in bits [6:0], [14:8] and [22:16], and an extent of 0 acts as 1. The offset flags sit in bits 7, 15 and 23 and are reported as a 3-bit field with X in bit 0, Y in bit 1 and Z in bit 2.
- R3: A descriptor write to a shape select below 3 while idle starts a fill, and `busy` then stays high for exactly 128 cycles. A descriptor write while busy is ignored.
- R4: Table entry i holds `(x + y*xsz + z*xsz*ysz) mod 256`, where (x, y, z) is the counter state after i steps from (0,0,0).
- R5: The permutation code in bits [26:24] selects the order of the dimensions, fastest first: 0=XYZ, 1=XZY, 2=YXZ, 3=YZX, 4=ZXY, 5=ZYX. Codes 6 and 7 behave as code 0.
- R6: The fastest dimension increments on each step. A dimension that reaches its extent wraps to 0 and carries into the next one in the order. When the slowest dimension wraps, the counter is back at (0,0,0).
- R7: Binding slot k occupies bits [8k+7:8k]: the register number in [8k+4:8k] and the shape select in [8k+6:8k+5]. A slot holding register 0 or shape select 3 is inactive. A lookup of register 0 is never remapped. When several slots match, the lowest slot wins.
- R8: For privilege codes 2'b01 and 2'b11 the lookup passes through (`res_index` = element, `res_remapped` = 0). Codes 2'b00 and 2'b10 allow remapping.
- R9: A lookup accepted at a clock edge (`lk_valid` with `lk_ready`) yields `res_valid`, `res_index`, `res_remapped` and `res_offs` after that edge and for one cycle only. `res_offs` is the bound shape's offset flags, or 0 on pass-through.
- R10: `lk_ready` is low while busy. A lookup offered then is dropped and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 2 | Shape descriptor select |
| desc_data | input | 32 | Descriptor word |
| bind_we | input | 1 | Binding register write strobe |
| bind_data | input | 24 | Three binding slots |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_reg | input | 5 | Register number of the access |
| lk_priv | input | 2 | Privilege level of the access |
| lk_elem | input | 7 | Element number |
| res_valid | output | 1 | Lookup result valid |
| res_index | output | 8 | Translated element index |
| res_remapped | output | 1 | Result came from a shape table |
| res_offs | output | 3 | Offset flags of the bound shape |
| busy | output | 1 | Table fill in progress |

## Verification
A fill starts at the edge that accepts the descriptor write. `busy` is high from the next sample point through the 128th, and the table is complete once `busy` reads low. The bench therefore counts busy cycles from the write and starts lookups only after `busy` has fallen. Each lookup is driven before one rising edge and its result is sampled on the falling edge that follows, which is the one cycle in which the result is valid. Stall and ignored-write cases are sampled in the cycle right after the write, while `busy` is known to be high.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int EXT_W  = 7;
    localparam int IDX_W  = 8;
    localparam int DESC_W = 32;
    localparam int REG_W  = 5;
    localparam int SLOT_W = 8;
    localparam int NSLOT  = 3;

    localparam logic [1:0] PRIV_SUP     = 2'b01;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [2:0] {
        PERM_XYZ = 3'd0,
        PERM_XZY = 3'd1,
        PERM_YXZ = 3'd2,
        PERM_YZX = 3'd3,
        PERM_ZXY = 3'd4,
        PERM_ZYX = 3'd5
    } perm_e;

    // index 0 = X, 1 = Y, 2 = Z
    typedef logic [2:0][EXT_W-1:0] coord_t;
    // entry 0 = fastest dimension
    typedef logic [2:0][1:0] order_t;

    typedef struct packed {
        coord_t     ext;
        logic [2:0] offs;
        perm_e      perm;
    } shape_t;

    function automatic shape_t decode_shape(input logic [DESC_W-1:0] w);
        shape_t s;
        for (int d = 0; d < 3; d++) begin
            logic [EXT_W-1:0] e;
            e         = w[d*8 +: EXT_W];
            s.ext[d]  = (e == '0) ? EXT_W'(1) : e;
            s.offs[d] = w[d*8 + 7];
        end
        s.perm = perm_e'(w[26:24]);
        return s;
    endfunction

    function automatic order_t perm_order(input perm_e p);
        order_t o;
        case (p)
            PERM_XZY: o = {2'd1, 2'd2, 2'd0};
            PERM_YXZ: o = {2'd2, 2'd0, 2'd1};
            PERM_YZX: o = {2'd0, 2'd2, 2'd1};
            PERM_ZXY: o = {2'd1, 2'd0, 2'd2};
            PERM_ZYX: o = {2'd0, 2'd1, 2'd2};
            default:  o = {2'd2, 2'd1, 2'd0};
        endcase
        return o;
    endfunction

    function automatic coord_t next_coord(input coord_t c, input coord_t ext, input perm_e p);
        order_t o;
        coord_t n;
        logic   carry;
        o     = perm_order(p);
        n     = c;
        carry = 1'b1;
        for (int j = 0; j < 3; j++) begin
            if (carry) begin
                if (n[o[j]] == ext[o[j]] - EXT_W'(1)) begin
                    n[o[j]] = '0;
                end else begin
                    n[o[j]] = n[o[j]] + EXT_W'(1);
                    carry   = 1'b0;
                end
            end
        end
        return n;
    endfunction

    function automatic logic [IDX_W-1:0] lin_index(input coord_t c, input coord_t ext);
        logic [IDX_W-1:0] xs;
        logic [IDX_W-1:0] xys;
        xs  = IDX_W'(ext[0]);
        xys = xs * IDX_W'(ext[1]);
        return IDX_W'(c[0]) + IDX_W'(c[1]) * xs + IDX_W'(c[2]) * xys;
    endfunction

endpackage

// File: rtl/remap_walker.sv
module remap_walker
    import remap_pkg::*;
#(
    parameter  int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  shape_t            start_shape,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [IDX_W-1:0]  wr_data
);

    shape_t            cur;
    coord_t            pos;
    logic [ADDR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
            pos  <= '0;
            ptr  <= '0;
        end else if (start && !busy) begin
            cur  <= start_shape;
            pos  <= '0;
            ptr  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            pos <= next_coord(pos, cur.ext, cur.perm);
            ptr <= ptr + ADDR_W'(1);
            if (ptr == ADDR_W'(DEPTH - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign wr_en   = busy;
    assign wr_addr = ptr;
    assign wr_data = lin_index(pos, cur.ext);

endmodule

// File: rtl/remap_select.sv
module remap_select
    import remap_pkg::*;
#(
    parameter  int NSHAPE = 3,
    localparam int SEL_W  = $clog2(NSHAPE)
) (
    input  logic [NSLOT*SLOT_W-1:0] binds,
    input  logic [REG_W-1:0]        reg_num,
    input  logic [1:0]              priv,
    output logic                    hit,
    output logic [SEL_W-1:0]        shape_idx
);

    logic [NSLOT-1:0]            match;
    logic [NSLOT-1:0][SEL_W-1:0] slot_shape;
    logic                        allowed;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [REG_W-1:0] slot_reg;
        assign slot_reg      = binds[k*SLOT_W +: REG_W];
        assign slot_shape[k] = binds[k*SLOT_W + REG_W +: SEL_W];
        assign match[k]      = (slot_reg != '0) && (slot_reg == reg_num)
                             && (32'(slot_shape[k]) < NSHAPE);
    end

    assign allowed = (priv != PRIV_SUP) && (priv != PRIV_MACHINE) && (reg_num != '0);

    always_comb begin
        hit       = 1'b0;
        shape_idx = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit       = allowed;
                shape_idx = slot_shape[k];
            end
        end
    end

endmodule

// File: rtl/shape_remapper.sv
module shape_remapper
    import remap_pkg::*;
#(
    parameter  int NSHAPE = 3,
    parameter  int DEPTH  = 128,
    localparam int SEL_W  = $clog2(NSHAPE),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    desc_we,
    input  logic [SEL_W-1:0]        desc_sel,
    input  logic [DESC_W-1:0]       desc_data,
    input  logic                    bind_we,
    input  logic [NSLOT*SLOT_W-1:0] bind_data,
    input  logic                    lk_valid,
    output logic                    lk_ready,
    input  logic [REG_W-1:0]        lk_reg,
    input  logic [1:0]              lk_priv,
    input  logic [ADDR_W-1:0]       lk_elem,
    output logic                    res_valid,
    output logic [IDX_W-1:0]        res_index,
    output logic                    res_remapped,
    output logic [2:0]              res_offs,
    output logic                    busy
);

    shape_t                  shapes [NSHAPE];
    logic [IDX_W-1:0]        tbl [NSHAPE][DEPTH];
    logic [NSLOT*SLOT_W-1:0] binds;
    logic [SEL_W-1:0]        fill_sel;
    shape_t                  new_shape;
    logic                    desc_go;
    logic                    lk_go;
    logic                    wr_en;
    logic [ADDR_W-1:0]       wr_addr;
    logic [IDX_W-1:0]        wr_data;
    logic                    hit;
    logic [SEL_W-1:0]        hit_shape;

    assign new_shape = decode_shape(desc_data);
    assign desc_go   = desc_we && !busy && (32'(desc_sel) < NSHAPE);
    assign lk_ready  = !busy;
    assign lk_go     = lk_valid && lk_ready;

    remap_walker #(.DEPTH(DEPTH)) u_walker (
        .clk         (clk),
        .rst         (rst),
        .start       (desc_go),
        .start_shape (new_shape),
        .busy        (busy),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    remap_select #(.NSHAPE(NSHAPE)) u_select (
        .binds     (binds),
        .reg_num   (lk_reg),
        .priv      (lk_priv),
        .hit       (hit),
        .shape_idx (hit_shape)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSHAPE; k++) begin
                shapes[k] <= decode_shape('0);
            end
            fill_sel <= '0;
            binds    <= '0;
        end else begin
            if (desc_go) begin
                shapes[desc_sel] <= new_shape;
                fill_sel         <= desc_sel;
            end
            if (bind_we) begin
                binds <= bind_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tbl[fill_sel][wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_index    <= '0;
            res_remapped <= 1'b0;
            res_offs     <= '0;
        end else begin
            res_valid <= lk_go;
            if (lk_go) begin
                if (hit) begin
                    res_index    <= tbl[hit_shape][lk_elem];
                    res_remapped <= 1'b1;
                    res_offs     <= shapes[hit_shape].offs;
                end else begin
                    res_index    <= IDX_W'(lk_elem);
                    res_remapped <= 1'b0;
                    res_offs     <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/remap_checker.sv
module remap_checker
    import remap_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              desc_we,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic [REG_W-1:0]  lk_reg,
    input logic [1:0]        lk_priv,
    input logic [ADDR_W-1:0] lk_elem,
    input logic              busy,
    input logic              res_valid,
    input logic [IDX_W-1:0]  res_index,
    input logic              res_remapped
);

    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run <= '0;
        end else begin
            run <= run + 16'd1;
        end
    end

    p_busy_window_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (32'(run) < DEPTH));

    p_fill_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(desc_we));

    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(lk_valid && lk_ready));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && busy) |=> !res_valid);

    p_priv_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(lk_priv) == PRIV_SUP || $past(lk_priv) == PRIV_MACHINE))
        |-> (!res_remapped && res_index == IDX_W'($past(lk_elem))));

    p_reg0_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(lk_reg) == '0) |-> !res_remapped);

endmodule

bind shape_remapper remap_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_remap_checker (
    .clk          (clk),
    .rst          (rst),
    .desc_we      (desc_we),
    .lk_valid     (lk_valid),
    .lk_ready     (lk_ready),
    .lk_reg       (lk_reg),
    .lk_priv      (lk_priv),
    .lk_elem      (lk_elem),
    .busy         (busy),
    .res_valid    (res_valid),
    .res_index    (res_index),
    .res_remapped (res_remapped)
);

// File: tb/test_shape_remapper.sv
module test_shape_remapper;
    import remap_pkg::*;

    localparam int DEPTH  = 128;
    localparam int NSHAPE = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        desc_we;
    logic [1:0]  desc_sel;
    logic [31:0] desc_data;
    logic        bind_we;
    logic [23:0] bind_data;
    logic        lk_valid;
    logic        lk_ready;
    logic [4:0]  lk_reg;
    logic [1:0]  lk_priv;
    logic [6:0]  lk_elem;
    logic        res_valid;
    logic [7:0]  res_index;
    logic        res_remapped;
    logic [2:0]  res_offs;
    logic        busy;

    always #2 clk = ~clk;

    shape_remapper #(.NSHAPE(NSHAPE), .DEPTH(DEPTH)) i_shape_remapper (
        .clk(clk), .rst(rst), .desc_we(desc_we), .desc_sel(desc_sel), .desc_data(desc_data),
        .bind_we(bind_we), .bind_data(bind_data), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_reg(lk_reg), .lk_priv(lk_priv), .lk_elem(lk_elem), .res_valid(res_valid),
        .res_index(res_index), .res_remapped(res_remapped), .res_offs(res_offs), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int ref_tbl[DEPTH];
    int ref0[DEPTH];
    int ref1[DEPTH];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_desc(input int xs, input int ys, input int zs,
                                            input int perm, input int offs);
        return 32'(xs) | (32'(ys) << 8) | (32'(zs) << 16)
             | (32'(offs & 1) << 7) | (32'((offs >> 1) & 1) << 15)
             | (32'((offs >> 2) & 1) << 23) | (32'(perm) << 24);
    endfunction

    // nested-loop model: outer loop is the slowest dimension
    task automatic build_ref(input int xs, input int ys, input int zs, input int perm);
        int e[3];
        int o[3];
        int k;
        int c[3];
        e[0] = (xs == 0) ? 1 : xs;
        e[1] = (ys == 0) ? 1 : ys;
        e[2] = (zs == 0) ? 1 : zs;
        case (perm)
            1:       o = '{0, 2, 1};
            2:       o = '{1, 0, 2};
            3:       o = '{1, 2, 0};
            4:       o = '{2, 0, 1};
            5:       o = '{2, 1, 0};
            default: o = '{0, 1, 2};
        endcase
        k = 0;
        while (k < DEPTH) begin
            for (int a = 0; a < e[o[2]]; a++) begin
                for (int b = 0; b < e[o[1]]; b++) begin
                    for (int f = 0; f < e[o[0]]; f++) begin
                        if (k < DEPTH) begin
                            c[o[2]] = a;
                            c[o[1]] = b;
                            c[o[0]] = f;
                            ref_tbl[k] = (c[0] + c[1] * e[0] + c[2] * e[0] * e[1]) % 256;
                            k++;
                        end
                    end
                end
            end
        end
    endtask

    task automatic write_desc(input int sel, input logic [31:0] d);
        @(negedge clk);
        desc_we   = 1'b1;
        desc_sel  = 2'(sel);
        desc_data = d;
        @(negedge clk);
        desc_we   = 1'b0;
    endtask

    task automatic write_bind(input logic [23:0] d);
        @(negedge clk);
        bind_we   = 1'b1;
        bind_data = d;
        @(negedge clk);
        bind_we   = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic do_lookup(input int r, input int pr, input int el);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_reg   = 5'(r);
        lk_priv  = 2'(pr);
        lk_elem  = 7'(el);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    function automatic logic [23:0] slot(input int k, input int r, input int sh);
        return 24'((r & 31) | ((sh & 3) << 5)) << (8 * k);
    endfunction

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int sx[3];
        int sy[3];
        int sz[3];
        string tg[3];
        sx = '{3, 5, 20};
        sy = '{4, 0, 13};
        sz = '{5, 7, 9};
        tg = '{"R5", "R2", "R4"};

        rst = 1'b1; desc_we = 1'b0; desc_sel = '0; desc_data = '0;
        bind_we = 1'b0; bind_data = '0; lk_valid = 1'b0; lk_reg = '0; lk_priv = '0; lk_elem = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(lk_ready == 1'b1, "R1 lk_ready", int'(lk_ready), 1);
        do_lookup(5, 0, 9);
        chk(res_valid && !res_remapped && res_index == 8'd9, "R1 passthrough",
            int'(res_index), 9);

        // sweep all permutation codes over three extent sets
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 8; p++) begin
                int sel;
                sel = p % 3;
                build_ref(sx[s], sy[s], sz[s], p);
                write_desc(sel, mk_desc(sx[s], sy[s], sz[s], p, p));
                wait_idle(cyc);
                chk(cyc == DEPTH, "R3 busy length", cyc, DEPTH);
                write_bind(slot(0, 7, sel));
                for (int el = 0; el < DEPTH; el++) begin
                    do_lookup(7, 0, el);
                    chk(res_valid && res_remapped && int'(res_index) == ref_tbl[el],
                        tg[s], int'(res_index), ref_tbl[el]);
                    if (el == 0) begin
                        chk(int'(res_offs) == p, "R2 offs", int'(res_offs), p);
                    end
                    if (s == 0 && el == 60) begin
                        chk(res_index == 8'd0, "R6 wrap to origin", int'(res_index), 0);
                    end
                end
                // R9: result lasts one cycle only
                @(negedge clk);
                chk(res_valid == 1'b0, "R9 single cycle", int'(res_valid), 0);
            end
        end

        // reference tables for the directed cases
        build_ref(3, 4, 5, 0);
        for (int i = 0; i < DEPTH; i++) ref0[i] = ref_tbl[i];
        build_ref(3, 4, 5, 5);
        for (int i = 0; i < DEPTH; i++) ref1[i] = ref_tbl[i];

        // R3: second write during busy is ignored; R10: stall
        write_desc(0, mk_desc(3, 4, 5, 0, 0));
        chk(lk_ready == 1'b0, "R10 ready low", int'(lk_ready), 0);
        lk_valid = 1'b1; lk_reg = 5'd7; lk_priv = 2'd0; lk_elem = 7'd3;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(res_valid == 1'b0, "R10 dropped", int'(res_valid), 0);
        desc_we = 1'b1; desc_sel = 2'd0; desc_data = mk_desc(2, 2, 2, 5, 7);
        @(negedge clk);
        desc_we = 1'b0;
        wait_idle(cyc);
        write_desc(1, mk_desc(3, 4, 5, 5, 2));
        wait_idle(cyc);
        write_bind(slot(0, 7, 0));
        for (int el = 0; el < DEPTH; el += 9) begin
            do_lookup(7, 0, el);
            chk(int'(res_index) == ref0[el], "R3 ignored write", int'(res_index), ref0[el]);
        end
        chk(res_offs == 3'd0, "R3 offs unchanged", int'(res_offs), 0);

        // R8: privilege
        do_lookup(7, 1, 10);
        chk(!res_remapped && res_index == 8'd10, "R8 supervisor", int'(res_index), 10);
        do_lookup(7, 3, 10);
        chk(!res_remapped && res_index == 8'd10, "R8 machine", int'(res_index), 10);
        do_lookup(7, 2, 10);
        chk(res_remapped && int'(res_index) == ref0[10], "R8 code 2 remaps",
            int'(res_index), ref0[10]);

        // R7: register 0, priority, inactive slot
        write_bind(slot(0, 0, 0) | slot(1, 9, 1));
        do_lookup(0, 0, 11);
        chk(!res_remapped && res_index == 8'd11, "R7 register 0", int'(res_index), 11);
        do_lookup(9, 0, 11);
        chk(res_remapped && int'(res_index) == ref1[11], "R7 slot1 match",
            int'(res_index), ref1[11]);
        chk(res_offs == 3'd2, "R7 slot1 offs", int'(res_offs), 2);
        write_bind(slot(0, 9, 0) | slot(1, 9, 1));
        do_lookup(9, 0, 11);
        chk(int'(res_index) == ref0[11], "R7 lowest slot wins", int'(res_index), ref0[11]);
        write_bind(slot(0, 9, 3) | slot(1, 9, 1));
        do_lookup(9, 0, 13);
        chk(int'(res_index) == ref1[13], "R7 shape 3 inactive", int'(res_index), ref1[13]);
        do_lookup(12, 0, 13);
        chk(!res_remapped && res_index == 8'd13, "R7 unbound", int'(res_index), 13);

        summary();
        $finish;
    end

endmodule